// File: doc/BRIEF.md
# Single-Cycle Harvard Processor Core

This block is a 16-bit processor that fetches one instruction and completes it in the same clock cycle, loads, stores, branches and jumps included. The instruction store and the data store are separate arrays. Each array's depth is set by an address-width parameter. Each cycle, the program counter reads an instruction word, and a combinational decoder turns it into a control word. That control word steers an eight-entry register file, a function unit (arithmetic, logic and shift), an operand multiplexer and a write-back multiplexer. The register file write and the data store write both happen at the next rising edge.

Programs are written into the instruction store through a plain write port, normally while reset is held. There is no streaming traffic at the block's edge, so every pin is a plain control or status signal. There is no valid/ready handshake and no back-pressure.

The port list also carries, as outputs, the register write, the data-store write and the status flags of the current instruction. This lets the surrounding logic observe what the core commits.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset, sampled at a rising edge, sets the program counter to 0. Register and data-store contents are not cleared.
- R2: Any instruction other than a taken branch or a jump advances the program counter by exactly 1 per cycle.
- R3: The instruction word holds the opcode in bits 15:9, the destination DR in 8:6, source A (SA) in 5:3 and source B (SB) in 2:0. The register operations each write R[DR] at the next edge:
  - copy A (0000000), A+1 (0000001), A+B (0000010), A−B (0000101), A−1 (0000110)
  - AND (0001000), OR (0001001), XOR (0001010)
  - NOT A (0001011), copy B (0001100)
  - All arithmetic wraps modulo 2^16.
- R4: Shift right (0001101) and shift left (0001110) take their operand from R[SB], move it by one bit with a zero filled in, and ignore SA.
- R5: Load-immediate (1001100) writes the zero-filled 3-bit field in bits 2:0 into R[DR] and ignores SA. Add-immediate (1000010) writes R[SA] plus that zero-filled value.
- R6: Store (0100000) writes R[SB] to data address R[SA] and writes no register. Load (0010000) writes the data word at address R[SA] into R[DR], and this includes a word stored by the previous instruction.
- R7: Branch-if-zero (1100000) and branch-if-negative (1100001) test R[SA]. When the test holds, the next PC is PC plus the sign-extended 6-bit offset {bits 8:6, bits 2:0}. Otherwise the next PC is PC+1. Neither writes a register or the data store.
- R8: Jump (1110000) loads the PC with the low bits of R[SA] and writes nothing.
- R9: Flag N equals bit 15 of the function-unit result, and flag Z is 1 exactly when that result is zero. For branch, load and store instructions, that result is R[SA].
- R10: Any opcode not listed above writes no register and no data word, and advances the PC by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the program counter |
| imem_we | input | 1 | Instruction-store write enable |
| imem_waddr | input | IAW | Instruction-store write address |
| imem_wdata | input | 16 | Instruction word to write |
| pc | output | IAW | Address of the instruction now executing |
| rf_we | output | 1 | Register write committed at the next edge |
| rf_waddr | output | 3 | Register being written |
| rf_wdata | output | 16 | Value being written to the register |
| dm_we | output | 1 | Data-store write committed at the next edge |
| dm_addr | output | DAW | Data-store address (from source A) |
| dm_wdata | output | 16 | Data-store write value (from source B) |
| flag_n | output | 1 | Sign of the function-unit result |
| flag_z | output | 1 | Function-unit result is zero |

## Verification
Several programs drive the core, and each is aimed at one path.

- A register-arithmetic program uses operands whose AND, OR and XOR results all differ, which exposes any swapped function code. It also wraps A+1 from all-ones to zero, which exposes carry and Z errors.
- A shift program puts an all-ones-high pattern on source B while source A holds something else. This separates the shift direction, the zero fill and the operand source.
- An immediate program sets the SA field to a non-zero register during load-immediate, which shows whether that field is ignored.
- A memory program stores and then immediately loads back. This shows that a write is visible one cycle later, and that a store commits no register.
- A branch program takes and declines each branch kind, jumps through a register, executes an undefined word and branches backwards. This separates the offset sign, the condition choice and the counting path.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned RAW = 3;

  typedef enum logic [3:0] {
    FS_PASSA = 4'd0,  FS_INC  = 4'd1,  FS_ADD   = 4'd2,  FS_SUB = 4'd5,
    FS_DEC   = 4'd6,  FS_AND  = 4'd8,  FS_OR    = 4'd9,  FS_XOR = 4'd10,
    FS_NOT   = 4'd11, FS_PASSB = 4'd12, FS_SHR  = 4'd13, FS_SHL = 4'd14
  } fs_e;

  localparam logic [6:0] OP_MOVA = 7'b0000000;
  localparam logic [6:0] OP_INC  = 7'b0000001;
  localparam logic [6:0] OP_ADD  = 7'b0000010;
  localparam logic [6:0] OP_SUB  = 7'b0000101;
  localparam logic [6:0] OP_DEC  = 7'b0000110;
  localparam logic [6:0] OP_AND  = 7'b0001000;
  localparam logic [6:0] OP_OR   = 7'b0001001;
  localparam logic [6:0] OP_XOR  = 7'b0001010;
  localparam logic [6:0] OP_NOT  = 7'b0001011;
  localparam logic [6:0] OP_MOVB = 7'b0001100;
  localparam logic [6:0] OP_SHR  = 7'b0001101;
  localparam logic [6:0] OP_SHL  = 7'b0001110;
  localparam logic [6:0] OP_LDI  = 7'b1001100;
  localparam logic [6:0] OP_ADI  = 7'b1000010;
  localparam logic [6:0] OP_LD   = 7'b0010000;
  localparam logic [6:0] OP_ST   = 7'b0100000;
  localparam logic [6:0] OP_BRZ  = 7'b1100000;
  localparam logic [6:0] OP_BRN  = 7'b1100001;
  localparam logic [6:0] OP_JMP  = 7'b1110000;

  // Control word produced by the decoder for one instruction.
  typedef struct packed {
    logic [RAW-1:0] dst;
    logic [RAW-1:0] srca;
    logic [RAW-1:0] srcb;
    logic           use_k;    // B operand is the zero-filled constant
    fs_e            fs;
    logic           from_mem; // write-back takes the data-store word
    logic           reg_wr;
    logic           mem_wr;
    logic           pc_ld;    // jump or branch
    logic           is_jmp;
    logic           on_neg;   // branch condition is N rather than Z
  } ctrl_t;

  function automatic logic opcode_known(input logic [6:0] op);
    case (op)
      OP_MOVA, OP_INC, OP_ADD, OP_SUB, OP_DEC, OP_AND, OP_OR, OP_XOR,
      OP_NOT, OP_MOVB, OP_SHR, OP_SHL, OP_LDI, OP_ADI, OP_LD, OP_ST,
      OP_BRZ, OP_BRN, OP_JMP: opcode_known = 1'b1;
      default:                opcode_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sc_ram.sv
// Word array with one synchronous write port and one combinational read port.
module sc_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sc_regfile.sv
// Register file: two combinational reads, one write at the rising edge.
module sc_regfile #(
  parameter int unsigned NREG = 8,
  parameter int unsigned W    = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [W-1:0]            rdata_a,
  output logic [W-1:0]            rdata_b
);
  localparam int unsigned AW = $clog2(NREG);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/sc_decode.sv
// Combinational instruction decoder; unknown opcodes become a no-op.
module sc_decode
  import sc_pkg::*;
(
  input  logic [DW-1:0] instr,
  output ctrl_t         ctl
);
  logic [6:0] op;
  assign op = instr[15:9];

  always_comb begin
    ctl          = '0;
    ctl.dst      = instr[8:6];
    ctl.srca     = instr[5:3];
    ctl.srcb     = instr[2:0];
    ctl.fs       = FS_PASSA;
    case (op)
      OP_MOVA: begin ctl.fs = FS_PASSA; ctl.reg_wr = 1'b1; end
      OP_INC:  begin ctl.fs = FS_INC;   ctl.reg_wr = 1'b1; end
      OP_ADD:  begin ctl.fs = FS_ADD;   ctl.reg_wr = 1'b1; end
      OP_SUB:  begin ctl.fs = FS_SUB;   ctl.reg_wr = 1'b1; end
      OP_DEC:  begin ctl.fs = FS_DEC;   ctl.reg_wr = 1'b1; end
      OP_AND:  begin ctl.fs = FS_AND;   ctl.reg_wr = 1'b1; end
      OP_OR:   begin ctl.fs = FS_OR;    ctl.reg_wr = 1'b1; end
      OP_XOR:  begin ctl.fs = FS_XOR;   ctl.reg_wr = 1'b1; end
      OP_NOT:  begin ctl.fs = FS_NOT;   ctl.reg_wr = 1'b1; end
      OP_MOVB: begin ctl.fs = FS_PASSB; ctl.reg_wr = 1'b1; end
      OP_SHR:  begin ctl.fs = FS_SHR;   ctl.reg_wr = 1'b1; end
      OP_SHL:  begin ctl.fs = FS_SHL;   ctl.reg_wr = 1'b1; end
      OP_LDI:  begin ctl.fs = FS_PASSB; ctl.use_k = 1'b1; ctl.reg_wr = 1'b1; end
      OP_ADI:  begin ctl.fs = FS_ADD;   ctl.use_k = 1'b1; ctl.reg_wr = 1'b1; end
      OP_LD:   begin ctl.from_mem = 1'b1; ctl.reg_wr = 1'b1; end
      OP_ST:   begin ctl.mem_wr = 1'b1; end
      OP_BRZ:  begin ctl.pc_ld = 1'b1; end
      OP_BRN:  begin ctl.pc_ld = 1'b1; ctl.on_neg = 1'b1; end
      OP_JMP:  begin ctl.pc_ld = 1'b1; ctl.is_jmp = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_funit.sv
// Function unit: arithmetic, logic and one-bit shifts, with N and Z.
module sc_funit
  import sc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fs_e          fs,
  output logic [W-1:0] f,
  output logic         n,
  output logic         z
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    case (fs)
      FS_PASSA: f = a;
      FS_INC:   f = a + ONE;
      FS_ADD:   f = a + b;
      FS_SUB:   f = a - b;
      FS_DEC:   f = a - ONE;
      FS_AND:   f = a & b;
      FS_OR:    f = a | b;
      FS_XOR:   f = a ^ b;
      FS_NOT:   f = ~a;
      FS_PASSB: f = b;
      FS_SHR:   f = {1'b0, b[W-1:1]};
      FS_SHL:   f = {b[W-2:0], 1'b0};
      default:  f = a;
    endcase
  end

  assign n = f[W-1];
  assign z = (f == '0);
endmodule

// File: rtl/sc_pc.sv
// Program counter with branch control: count, branch on N/Z, or jump.
module sc_pc #(
  parameter int unsigned IAW = 8,
  parameter int unsigned W   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pc_ld,
  input  logic           is_jmp,
  input  logic           on_neg,
  input  logic           n,
  input  logic           z,
  input  logic [5:0]     offs,
  input  logic [W-1:0]   jtgt,
  output logic [IAW-1:0] pc
);
  logic [IAW-1:0] pc_q, pc_inc, pc_br, pc_nxt;
  logic           cond;

  assign pc_inc = pc_q + IAW'(1);
  assign pc_br  = pc_q + {{(IAW-6){offs[5]}}, offs};
  assign cond   = on_neg ? n : z;

  always_comb begin
    pc_nxt = pc_inc;
    if (pc_ld) begin
      if (is_jmp)    pc_nxt = jtgt[IAW-1:0];
      else if (cond) pc_nxt = pc_br;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign pc = pc_q;
endmodule

// File: rtl/sc_core.sv
// Top: single-cycle core with separate instruction and data stores.
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IAW = 8,
  parameter int unsigned DAW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_we,
  input  logic [IAW-1:0]  imem_waddr,
  input  logic [15:0]     imem_wdata,
  output logic [IAW-1:0]  pc,
  output logic            rf_we,
  output logic [2:0]      rf_waddr,
  output logic [15:0]     rf_wdata,
  output logic            dm_we,
  output logic [DAW-1:0]  dm_addr,
  output logic [15:0]     dm_wdata,
  output logic            flag_n,
  output logic            flag_z
);
  localparam int unsigned NREG = 1 << RAW;

  logic [DW-1:0] instr, bus_a, reg_b, bus_b, konst, fres, dm_rdata, bus_d;
  ctrl_t         ctl;

  sc_ram #(.AW(IAW), .W(DW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc), .rdata(instr)
  );

  sc_decode u_dec (.instr(instr), .ctl(ctl));

  sc_regfile #(.NREG(NREG), .W(DW)) u_rf (
    .clk(clk), .we(ctl.reg_wr), .waddr(ctl.dst), .wdata(bus_d),
    .raddr_a(ctl.srca), .raddr_b(ctl.srcb), .rdata_a(bus_a), .rdata_b(reg_b)
  );

  assign konst = {{(DW-3){1'b0}}, instr[2:0]};
  assign bus_b = ctl.use_k ? konst : reg_b;

  sc_funit #(.W(DW)) u_fu (
    .a(bus_a), .b(bus_b), .fs(ctl.fs), .f(fres), .n(flag_n), .z(flag_z)
  );

  sc_ram #(.AW(DAW), .W(DW)) u_dmem (
    .clk(clk), .we(ctl.mem_wr), .waddr(bus_a[DAW-1:0]), .wdata(bus_b),
    .raddr(bus_a[DAW-1:0]), .rdata(dm_rdata)
  );

  assign bus_d = ctl.from_mem ? dm_rdata : fres;

  sc_pc #(.IAW(IAW), .W(DW)) u_pc (
    .clk(clk), .rst(rst), .pc_ld(ctl.pc_ld), .is_jmp(ctl.is_jmp),
    .on_neg(ctl.on_neg), .n(flag_n), .z(flag_z),
    .offs({instr[8:6], instr[2:0]}), .jtgt(bus_a), .pc(pc)
  );

  assign rf_we    = ctl.reg_wr;
  assign rf_waddr = ctl.dst;
  assign rf_wdata = bus_d;
  assign dm_we    = ctl.mem_wr;
  assign dm_addr  = bus_a[DAW-1:0];
  assign dm_wdata = bus_b;
endmodule

// File: rtl/sc_core_chk.sv
// Temporal checks on the core, attached by bind.
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int unsigned IAW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [IAW-1:0] pc,
  input logic [15:0]    instr,
  input logic [15:0]    bus_a,
  input logic           rf_we,
  input logic [15:0]    rf_wdata,
  input logic           dm_we,
  input logic           flag_z,
  input logic           flag_n
);
  logic [6:0]     op;
  logic [IAW-1:0] br_tgt;
  assign op     = instr[15:9];
  assign br_tgt = pc + {{(IAW-6){instr[8]}}, instr[8:6], instr[2:0]};

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> pc == '0);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op[6:5] != 2'b11) |=> pc == $past(pc) + IAW'(1));

  // R6
  store_no_reg_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we);

  // R7
  brz_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BRZ && bus_a == '0) |=> pc == $past(br_tgt));

  // R7
  brn_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BRN && bus_a[15]) |=> pc == $past(br_tgt));

  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JMP) |=> pc == $past(bus_a[IAW-1:0]));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we && op != OP_LD) |-> (flag_z == (rf_wdata == '0) && flag_n == rf_wdata[15]));

  // R10
  unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
    !opcode_known(op) |-> (!rf_we && !dm_we));
endmodule

bind sc_core sc_core_chk #(.IAW(IAW)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr), .bus_a(bus_a),
  .rf_we(rf_we), .rf_wdata(rf_wdata), .dm_we(dm_we),
  .flag_z(flag_z), .flag_n(flag_n)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
  localparam int IAW = 8;
  localparam int DAW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           imem_we = 1'b0;
  logic [IAW-1:0] imem_waddr = '0;
  logic [15:0]    imem_wdata = '0;
  logic [IAW-1:0] pc;
  logic           rf_we, dm_we, flag_n, flag_z;
  logic [2:0]     rf_waddr;
  logic [15:0]    rf_wdata, dm_wdata;
  logic [DAW-1:0] dm_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sc_core #(.IAW(IAW), .DAW(DAW)) dut (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .pc(pc), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .flag_n(flag_n), .flag_z(flag_z)
  );

  function automatic logic [15:0] ri(input logic [6:0] op, input int dr, input int sa, input int sb);
    ri = {op, 3'(dr), 3'(sa), 3'(sb)};
  endfunction

  function automatic logic [15:0] br(input logic [6:0] op, input int sa, input logic [5:0] off);
    br = {op, off[5:3], 3'(sa), off[2:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [15:0] w);
    imem_we = 1'b1; imem_waddr = IAW'(addr); imem_wdata = w;
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic clear_prog();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < (1 << IAW); i++) put(i, 16'hFE00);
  endtask

  task automatic start();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check(pc == '0, "R1 pc after reset", 32'(pc), 0);
  endtask

  // Register write expected this cycle, then advance one cycle.
  task automatic ew(input string tag, input int epc, input int dr, input logic [15:0] d,
                    input bit en, input bit ez);
    check(pc == IAW'(epc), {tag, " R2 pc"}, 32'(pc), 32'(epc));
    check(rf_we && !dm_we, {tag, " write enables"}, {rf_we, dm_we}, 2'b10);
    check(rf_waddr == 3'(dr), {tag, " dest"}, 32'(rf_waddr), 32'(dr));
    check(rf_wdata == d, {tag, " data"}, 32'(rf_wdata), 32'(d));
    check(flag_n == en && flag_z == ez, {tag, " R9 flags"}, {flag_n, flag_z}, {en, ez});
    @(negedge clk);
  endtask

  // No write of any kind expected this cycle.
  task automatic enw(input string tag, input int epc);
    check(pc == IAW'(epc), {tag, " pc"}, 32'(pc), 32'(epc));
    check(!rf_we && !dm_we, {tag, " no write"}, {rf_we, dm_we}, 0);
    @(negedge clk);
  endtask

  task automatic est(input string tag, input int epc, input int addr, input logic [15:0] d);
    check(pc == IAW'(epc), {tag, " pc"}, 32'(pc), 32'(epc));
    check(dm_we && !rf_we, {tag, " R6 store enables"}, {dm_we, rf_we}, 2'b10);
    check(dm_addr == DAW'(addr), {tag, " R6 addr"}, 32'(dm_addr), 32'(addr));
    check(dm_wdata == d, {tag, " R6 data"}, 32'(dm_wdata), 32'(d));
    @(negedge clk);
  endtask

  task automatic t_alu();
    clear_prog();
    put(0,  ri(7'b1001100, 1, 0, 6));
    put(1,  ri(7'b1001100, 2, 0, 3));
    put(2,  ri(7'b0000010, 3, 1, 2));
    put(3,  ri(7'b0000101, 4, 2, 1));
    put(4,  ri(7'b0001000, 5, 1, 2));
    put(5,  ri(7'b0001001, 6, 1, 2));
    put(6,  ri(7'b0001010, 7, 1, 2));
    put(7,  ri(7'b0001011, 0, 1, 0));
    put(8,  ri(7'b0000001, 0, 4, 0));
    put(9,  ri(7'b0000110, 3, 3, 0));
    put(10, ri(7'b0000000, 5, 4, 0));
    put(11, ri(7'b0001100, 6, 0, 2));
    put(12, ri(7'b0000101, 7, 1, 1));
    put(13, ri(7'b0000001, 1, 0, 0));
    put(14, ri(7'b0000001, 2, 1, 0));
    start();
    ew("R5 ldi", 0, 1, 16'd6, 0, 0);
    ew("R5 ldi", 1, 2, 16'd3, 0, 0);
    ew("R3 add", 2, 3, 16'd9, 0, 0);
    ew("R3 sub", 3, 4, 16'hFFFD, 1, 0);
    ew("R3 and", 4, 5, 16'd2, 0, 0);
    ew("R3 or", 5, 6, 16'd7, 0, 0);
    ew("R3 xor", 6, 7, 16'd5, 0, 0);
    ew("R3 not", 7, 0, 16'hFFF9, 1, 0);
    ew("R3 inc", 8, 0, 16'hFFFE, 1, 0);
    ew("R3 dec", 9, 3, 16'd8, 0, 0);
    ew("R3 mova", 10, 5, 16'hFFFD, 1, 0);
    ew("R3 movb", 11, 6, 16'd3, 0, 0);
    ew("R3 sub zero", 12, 7, 16'd0, 0, 1);
    ew("R3 inc", 13, 1, 16'hFFFF, 1, 0);
    ew("R3 inc wrap", 14, 2, 16'd0, 0, 1);
  endtask

  task automatic t_shift();
    clear_prog();
    put(0, ri(7'b1001100, 1, 0, 5));
    put(1, ri(7'b0001110, 2, 7, 1));
    put(2, ri(7'b0001101, 3, 7, 1));
    put(3, ri(7'b0001011, 4, 1, 0));
    put(4, ri(7'b0001101, 5, 1, 4));
    put(5, ri(7'b0001110, 6, 1, 4));
    start();
    ew("R5 ldi", 0, 1, 16'd5, 0, 0);
    ew("R4 shl", 1, 2, 16'd10, 0, 0);
    ew("R4 shr", 2, 3, 16'd2, 0, 0);
    ew("R3 not", 3, 4, 16'hFFFA, 1, 0);
    ew("R4 shr zero fill", 4, 5, 16'h7FFD, 0, 0);
    ew("R4 shl", 5, 6, 16'hFFF4, 1, 0);
  endtask

  task automatic t_imm();
    clear_prog();
    put(0, ri(7'b1001100, 1, 0, 7));
    put(1, ri(7'b1000010, 2, 1, 7));
    put(2, ri(7'b1000010, 3, 2, 0));
    put(3, ri(7'b1001100, 4, 0, 0));
    put(4, ri(7'b1000010, 5, 4, 0));
    put(5, ri(7'b1001100, 6, 1, 3));
    start();
    ew("R5 ldi max", 0, 1, 16'd7, 0, 0);
    ew("R5 adi", 1, 2, 16'd14, 0, 0);
    ew("R5 adi zero", 2, 3, 16'd14, 0, 0);
    ew("R5 ldi zero", 3, 4, 16'd0, 0, 1);
    ew("R5 adi zero", 4, 5, 16'd0, 0, 1);
    ew("R5 ldi ignores sa", 5, 6, 16'd3, 0, 0);
  endtask

  task automatic t_mem();
    clear_prog();
    put(0, ri(7'b1001100, 1, 0, 4));
    put(1, ri(7'b1001100, 2, 0, 5));
    put(2, ri(7'b0100000, 0, 1, 2));
    put(3, ri(7'b0010000, 3, 1, 0));
    put(4, ri(7'b1000010, 4, 1, 1));
    put(5, ri(7'b0100000, 0, 4, 1));
    put(6, ri(7'b0010000, 6, 4, 0));
    put(7, ri(7'b0010000, 0, 1, 0));
    start();
    ew("R5 ldi", 0, 1, 16'd4, 0, 0);
    ew("R5 ldi", 1, 2, 16'd5, 0, 0);
    est("R6 st", 2, 4, 16'd5);
    ew("R6 ld after st", 3, 3, 16'd5, 0, 0);
    ew("R5 adi", 4, 4, 16'd5, 0, 0);
    est("R6 st", 5, 5, 16'd4);
    ew("R6 ld", 6, 6, 16'd4, 0, 0);
    ew("R6 ld", 7, 0, 16'd5, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    check(pc == '0, "R1 reset mid-run", 32'(pc), 0);
    rst = 1'b0;
    ew("R1 restart", 0, 1, 16'd4, 0, 0);
  endtask

  task automatic t_branch();
    clear_prog();
    put(0,  ri(7'b1001100, 6, 0, 0));
    put(1,  ri(7'b1001100, 2, 0, 6));
    put(2,  ri(7'b1001100, 3, 0, 2));
    put(3,  ri(7'b1001100, 7, 0, 4));
    put(4,  br(7'b1100000, 6, 6'd21));
    put(25, ri(7'b0000101, 1, 2, 3));
    put(26, br(7'b1100001, 1, 6'd5));
    put(27, br(7'b1100000, 2, 6'd5));
    put(28, ri(7'b0001011, 4, 3, 0));
    put(29, br(7'b1100001, 4, 6'd16));
    put(45, ri(7'b1000010, 2, 7, 3));
    put(46, ri(7'b1001100, 5, 0, 7));
    put(47, ri(7'b0001110, 5, 0, 5));
    put(48, ri(7'b1110000, 0, 5, 0));
    put(15, br(7'b1100000, 6, 6'b110100));
    start();
    ew("R5 ldi", 0, 6, 16'd0, 0, 1);
    ew("R5 ldi", 1, 2, 16'd6, 0, 0);
    ew("R5 ldi", 2, 3, 16'd2, 0, 0);
    ew("R5 ldi", 3, 7, 16'd4, 0, 0);
    check(flag_z == 1'b1, "R9 z on branch operand", 32'(flag_z), 1);
    enw("R7 brz taken", 4);
    ew("R3 sub", 25, 1, 16'd4, 0, 0);
    enw("R7 brn not taken", 26);
    enw("R7 brz not taken", 27);
    ew("R3 not", 28, 4, 16'hFFFD, 1, 0);
    enw("R7 brn taken", 29);
    ew("R5 adi", 45, 2, 16'd7, 0, 0);
    ew("R5 ldi", 46, 5, 16'd7, 0, 0);
    ew("R4 shl", 47, 5, 16'd14, 0, 0);
    enw("R8 jmp", 48);
    enw("R10 undefined op", 14);
    enw("R7 brz backward", 15);
    ew("R7 backward target", 3, 7, 16'd4, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_alu();
    t_shift();
    t_imm();
    t_mem();
    t_branch();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule